// File: doc/BRIEF.md
# Replica-Delay Supply Voltage Controller

This block closes the supply loop for one memory block. A replica read path feeds a chain of delay buffers. Flip-flops capture that chain at every clock edge and present the result as a thermometer word on `therm_i`. Bit 0 is the tap nearest the replica output. A set bit means the replica edge had passed that tap by the clock edge. From the number of captured taps, the controller steps an 8-bit supply request up or down. It stops when the replica delay plus a fixed margin of taps just fits in the cycle. One code step is 10 mV. With the default parameters the active range is 35..150 (0.35 V to 1.5 V).

The search starts at the highest supply and walks down. The first hold decision marks the minimum supply for the current clock setting. If that code lies below the body-bias threshold (60, which is 0.6 V), the controller turns on body bias. The loop then keeps tracking with the bias fixed. A change of the frequency setting restarts the search. In standby the controller requests a fixed retention supply. The loop stays frozen and the tracked code is kept for the return to active mode.

Top module: `dvfs_supply_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `vcode_o` is 150, `bias_en_o` is 0 and `locked_o` is 0; the controller starts in the search phase.
- R2: Let `n` be the number of set bits in `therm_i` (bit i set = tap i captured). At a decision edge, n < 6 raises the code by 1, n > 8 lowers it by 1, and 6 <= n <= 8 is a hold.
- R3: Outside standby, `vcode_o` stays within 35..150. A raise at 150 and a lower at 35 leave the code unchanged.
- R4: A decision edge loads the settle counter with `settle_cnt_i` when it is a raise, a lower, or the hold that turns on body bias. The next `settle_cnt_i` rising edges then make no decision. With `settle_cnt_i` = 0, every edge is a decision edge.
- R5: The first hold decision of a search ends the search. If the code is below 60 at that point, `bias_en_o` goes to 1. Bias never changes in the tracking phase.
- R6: An edge at which `freq_sel_i` differs from its value at the previous edge restarts the controller. The code returns to 150, bias is cleared, the hold count is cleared and the search phase begins.
- R7: In the tracking phase, `locked_o` is 1 once `lock_cnt_i` or more consecutive hold decisions have been made (at least one). Any raise, lower or restart clears it.
- R8: While `standby_i` is 1, `vcode_o` is 30 and `locked_o` is 0. No decision is made and the settle counter is reloaded every edge. After standby the tracked code reappears unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; delay capture happens on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Request retention supply and freeze the loop |
| freq_sel_i | input | 4 | Current clock frequency setting |
| therm_i | input | 12 | Captured replica delay chain, thermometer coded |
| settle_cnt_i | input | 8 | Edges to wait after a supply or bias change |
| lock_cnt_i | input | 6 | Consecutive holds required for lock |
| vcode_o | output | 8 | Supply request, 10 mV per step |
| bias_en_o | output | 1 | Body-bias enable for noise-margin repair |
| locked_o | output | 1 | Loop has settled at the current setting |

## Verification
The assertions assume that `freq_sel_i` and `standby_i` are driven and steady during reset. They also assume that the code stays in one piece, so it can move by at most one step per edge unless the frequency setting or standby changed. The bench changes every input only well after a rising edge, while reset is inactive or held steady. It feeds `therm_i` only proper thermometer words built from a count. It changes `lock_cnt_i` and `settle_cnt_i` only between decisions, so the one-step and lock-implies-stable properties are never fed inputs outside their assumptions.

// File: rtl/vdd_ctrl_pkg.sv
package vdd_ctrl_pkg;
  typedef enum logic [1:0] {DEC_HOLD, DEC_UP, DEC_DOWN} dec_e;
  typedef enum logic {PH_SEARCH, PH_TRACK} phase_e;
endpackage

// File: rtl/vdd_therm_decode.sv
module vdd_therm_decode
  import vdd_ctrl_pkg::*;
#(
  parameter int TAPS       = 12,
  parameter int REQ_TAPS   = 6,
  parameter int SLACK_TAPS = 2
) (
  input  logic [TAPS-1:0] therm_i,
  output dec_e            dec_o
);
  localparam int CW = $clog2(TAPS + 1);
  localparam logic [CW-1:0] LO = CW'(REQ_TAPS);
  localparam logic [CW-1:0] HI = CW'(REQ_TAPS + SLACK_TAPS);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + {{(CW-1){1'b0}}, therm_i[i]};
  end

  always_comb begin
    if (ones < LO)      dec_o = DEC_UP;
    else if (ones > HI) dec_o = DEC_DOWN;
    else                dec_o = DEC_HOLD;
  end
endmodule

// File: rtl/vdd_settle_timer.sv
module vdd_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] val_i,
  output logic                busy_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/vdd_code_step.sv
module vdd_code_step
  import vdd_ctrl_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int VMIN_CODE = 35,
  parameter int VMAX_CODE = 150
) (
  input  logic [CODE_W-1:0] code_i,
  input  dec_e              dec_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CMIN = CODE_W'(VMIN_CODE);
  localparam logic [CODE_W-1:0] CMAX = CODE_W'(VMAX_CODE);

  always_comb begin
    code_o = code_i;
    unique case (dec_i)
      DEC_UP:   if (code_i < CMAX) code_o = code_i + 1'b1;
      DEC_DOWN: if (code_i > CMIN) code_o = code_i - 1'b1;
      default:  code_o = code_i;
    endcase
  end
endmodule

// File: rtl/dvfs_supply_ctrl.sv
module dvfs_supply_ctrl
  import vdd_ctrl_pkg::*;
#(
  parameter int TAPS          = 12,
  parameter int REQ_TAPS      = 6,
  parameter int SLACK_TAPS    = 2,
  parameter int CODE_W        = 8,
  parameter int VMIN_CODE     = 35,
  parameter int VMAX_CODE     = 150,
  parameter int BIAS_THR_CODE = 60,
  parameter int STBY_CODE     = 30,
  parameter int FREQ_W        = 4,
  parameter int SETTLE_W      = 8,
  parameter int LOCK_W        = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                standby_i,
  input  logic [FREQ_W-1:0]   freq_sel_i,
  input  logic [TAPS-1:0]     therm_i,
  input  logic [SETTLE_W-1:0] settle_cnt_i,
  input  logic [LOCK_W-1:0]   lock_cnt_i,
  output logic [CODE_W-1:0]   vcode_o,
  output logic                bias_en_o,
  output logic                locked_o
);
  localparam logic [CODE_W-1:0] CMAX  = CODE_W'(VMAX_CODE);
  localparam logic [CODE_W-1:0] CTHR  = CODE_W'(BIAS_THR_CODE);
  localparam logic [CODE_W-1:0] CSTBY = CODE_W'(STBY_CODE);
  localparam logic [LOCK_W-1:0] HSAT  = '1;

  logic [CODE_W-1:0] code_q, code_nxt;
  logic [FREQ_W-1:0] freq_q;
  logic [LOCK_W-1:0] hold_q;
  logic              bias_q;
  phase_e            phase_q;
  dec_e              dec;
  logic              busy, freq_chg, sample, end_search, bias_on, load;

  vdd_therm_decode #(.TAPS(TAPS), .REQ_TAPS(REQ_TAPS), .SLACK_TAPS(SLACK_TAPS)) u_dec (
    .therm_i(therm_i), .dec_o(dec)
  );

  vdd_code_step #(.CODE_W(CODE_W), .VMIN_CODE(VMIN_CODE), .VMAX_CODE(VMAX_CODE)) u_step (
    .code_i(code_q), .dec_i(dec), .code_o(code_nxt)
  );

  assign freq_chg   = (freq_sel_i != freq_q);
  assign sample     = !standby_i && !busy && !freq_chg;
  assign end_search = sample && (dec == DEC_HOLD) && (phase_q == PH_SEARCH);
  assign bias_on    = end_search && (code_q < CTHR);
  assign load       = freq_chg || standby_i || bias_on || (sample && dec != DEC_HOLD);

  vdd_settle_timer #(.SETTLE_W(SETTLE_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .val_i(settle_cnt_i), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= CMAX;
      bias_q  <= 1'b0;
      phase_q <= PH_SEARCH;
      hold_q  <= '0;
      freq_q  <= '0;
    end else begin
      freq_q <= freq_sel_i;
      if (freq_chg) begin
        code_q  <= CMAX;
        bias_q  <= 1'b0;
        phase_q <= PH_SEARCH;
        hold_q  <= '0;
      end else if (sample) begin
        code_q <= code_nxt;
        if (dec != DEC_HOLD) begin
          hold_q <= '0;
        end else if (phase_q == PH_SEARCH) begin
          phase_q <= PH_TRACK;
          hold_q  <= '0;
          if (bias_on) bias_q <= 1'b1;
        end else if (hold_q != HSAT) begin
          hold_q <= hold_q + 1'b1;
        end
      end
    end
  end

  assign vcode_o   = standby_i ? CSTBY : code_q;
  assign bias_en_o = bias_q;
  assign locked_o  = !standby_i && (phase_q == PH_TRACK) && (hold_q != '0) && (hold_q >= lock_cnt_i);
endmodule

// File: rtl/vdd_ctrl_checker.sv
module vdd_ctrl_checker #(
  parameter int CODE_W        = 8,
  parameter int FREQ_W        = 4,
  parameter int VMIN_CODE     = 35,
  parameter int VMAX_CODE     = 150,
  parameter int BIAS_THR_CODE = 60,
  parameter int STBY_CODE     = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              standby_i,
  input logic [FREQ_W-1:0] freq_sel_i,
  input logic [CODE_W-1:0] vcode_o,
  input logic              bias_en_o,
  input logic              locked_o
);
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i |-> (vcode_o >= CODE_W'(VMIN_CODE) && vcode_o <= CODE_W'(VMAX_CODE))); // R3

  AST_STBY_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> (vcode_o == CODE_W'(STBY_CODE) && !locked_o)); // R8

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !$past(standby_i) && $past(freq_sel_i) == $past(freq_sel_i, 2)) |->
    (vcode_o == $past(vcode_o) || vcode_o == $past(vcode_o) + 1'b1 || vcode_o + 1'b1 == $past(vcode_o))); // R2

  AST_BIAS_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bias_en_o) |-> (standby_i || vcode_o < CODE_W'(BIAS_THR_CODE))); // R5

  AST_FREQ_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_sel_i != $past(freq_sel_i)) |=> (!bias_en_o && !locked_o && (standby_i || vcode_o == CODE_W'(VMAX_CODE)))); // R6

  AST_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !$past(standby_i)) |-> $stable(vcode_o)); // R7
endmodule

bind dvfs_supply_ctrl vdd_ctrl_checker #(
  .CODE_W(CODE_W), .FREQ_W(FREQ_W), .VMIN_CODE(VMIN_CODE), .VMAX_CODE(VMAX_CODE),
  .BIAS_THR_CODE(BIAS_THR_CODE), .STBY_CODE(STBY_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .freq_sel_i(freq_sel_i),
  .vcode_o(vcode_o), .bias_en_o(bias_en_o), .locked_o(locked_o)
);

// File: tb/tb_dvfs_supply_ctrl.sv
module tb_dvfs_supply_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        standby_i = 1'b0;
  logic [3:0]  freq_sel_i = '0;
  logic [11:0] therm_i = '0;
  logic [7:0]  settle_cnt_i = '0;
  logic [5:0]  lock_cnt_i = 6'd2;
  logic [7:0]  vcode_o;
  logic        bias_en_o, locked_o;
  int total = 0, bad = 0;

  dvfs_supply_ctrl dut (.*);

  always #4 clk_i = ~clk_i;

  localparam int NV = 8;
  localparam int V_ONES [NV] = '{10, 9, 3, 7, 7, 8, 12, 6};
  localparam int V_CODE [NV] = '{149, 148, 149, 149, 149, 149, 148, 148};
  localparam int V_LOCK [NV] = '{0, 0, 0, 0, 0, 1, 0, 0};

  function automatic logic [11:0] thermo(int n);
    return 12'((13'd1 << n) - 13'd1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 code in reset", vcode_o, 150);
    chk("R1 bias in reset", bias_en_o, 0);
    chk("R1 locked in reset", locked_o, 0);
    rst_ni = 1'b1;
    therm_i = thermo(7);
    #1;
    chk("R1 code after reset", vcode_o, 150);

    // R2 R5 R7 table walk, settle 0, lock after 2 holds
    for (int i = 0; i < NV; i++) begin
      therm_i = thermo(V_ONES[i]);
      tick();
      chk($sformatf("R2 table code step %0d", i), vcode_o, V_CODE[i]);
      chk($sformatf("R7 table lock step %0d", i), locked_o, V_LOCK[i]);
      chk($sformatf("R5 table bias step %0d", i), bias_en_o, 0);
    end

    // R8 standby freezes loop
    standby_i = 1'b1;
    therm_i = thermo(12);
    #1;
    chk("R8 standby supply", vcode_o, 30);
    for (int i = 0; i < 3; i++) tick();
    chk("R8 standby supply held", vcode_o, 30);
    chk("R8 standby unlocked", locked_o, 0);
    standby_i = 1'b0;
    therm_i = thermo(7);
    #1;
    chk("R8 code retained", vcode_o, 148);
    tick();
    chk("R7 lock after standby hold", locked_o, 1);
    chk("R8 code after exit", vcode_o, 148);

    // R4 settle window
    settle_cnt_i = 8'd3;
    therm_i = thermo(12);
    tick();
    chk("R4 first step", vcode_o, 147);
    chk("R7 step clears lock", locked_o, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 no decision in settle", vcode_o, 147);
    end
    tick();
    chk("R4 decision after settle", vcode_o, 146);
    therm_i = thermo(7);
    for (int i = 0; i < 4; i++) tick();
    settle_cnt_i = 8'd0;
    chk("R2 hold in band", vcode_o, 146);

    // R6 restart on frequency change
    freq_sel_i = 4'd1;
    therm_i = thermo(0);
    tick();
    chk("R6 restart code", vcode_o, 150);
    chk("R6 restart bias", bias_en_o, 0);
    chk("R6 restart lock", locked_o, 0);
    tick();
    chk("R3 clamp at max", vcode_o, 150);

    therm_i = thermo(12);
    for (int i = 0; i < 115; i++) tick();
    chk("R2 walked to floor", vcode_o, 35);
    tick();
    chk("R3 clamp at min", vcode_o, 35);

    therm_i = thermo(6);
    tick();
    chk("R5 bias on below threshold", bias_en_o, 1);
    chk("R5 code kept at bias on", vcode_o, 35);
    therm_i = thermo(0);
    tick();
    chk("R5 track with bias raise", vcode_o, 36);
    chk("R5 bias stays in track", bias_en_o, 1);
    therm_i = thermo(8);
    tick();
    chk("R7 one hold not locked", locked_o, 0);
    tick();
    chk("R7 locked after two holds", locked_o, 1);
    standby_i = 1'b1;
    #1;
    chk("R8 lock masked in standby", locked_o, 0);
    tick();
    standby_i = 1'b0;
    freq_sel_i = 4'd2;
    tick();
    chk("R6 bias cleared on restart", bias_en_o, 0);
    chk("R6 code back to max", vcode_o, 150);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule